// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block times the control strobes of one access to an external memory region. A start request accepted while the block is idle loads a cycle counter with zero and freezes the configuration for that access. Address strobe, read enable, write enable and an address-valid window are then asserted and released at the memory-clock cycles given by fields of a 16-bit configuration word. The access finishes with a one-cycle done pulse when the counter reaches the bus-cycle end.

Two timing modes exist. In fixed-wait mode the access length is set entirely by the word. In handshaking mode an acknowledge input is sampled at a programmed point while the enables are held; the access stretches until acknowledge is seen high. Handshaking is only legal when the memory clock runs at four times the system clock. A request whose fields are illegal, or whose edges are out of order, is refused: the strobes stay low and the block answers with done plus a configuration-error flag.

All strobes are active high. A strobe with assert offset A and release offset N is high in every cycle whose counter value c satisfies A <= c < N.

Top module: `ext_strobe_timer`

## Requirements
- R1: During and directly after synchronous reset (rst_n low), busy_o, done_o, cfg_err_o, as_o, re_o, we_o, addr_valid_o, bus16_o and mclk_sync_o are all 0.
- R2: A start_i high at a clock edge while idle is accepted: from that edge busy_o is 1 and the counter reads 0; start_i while busy has no effect on the access in progress.
- R3: done_o is 1 for exactly the cycle in which the counter equals the bus-cycle end (fixed mode: word bits [15:11]; handshaking mode: word bits [10:6]); busy_o falls at the next edge, so an unstalled access keeps busy_o high for end+1 cycles.
- R4: Fixed mode (hs_mode_i = 0): as_o is high for counter values in [bits [7:6], bits [10:8]); addr_valid_o is high for counter values in [0, bits [10:8]).
- R5: Fixed mode: the enable window is [EN_ON_FIXED (default 1), bits [15:11]); it drives re_o when write_i was 0 at acceptance and we_o when it was 1, never both.
- R6: Fixed mode: a request is refused when bits [10:8] are 0, when bits [10:8] are less than bits [7:6], or when bits [15:11] are less than 3 or less than EN_ON_FIXED.
- R7: Handshaking mode (hs_mode_i = 1): the enable window is [bits [3:2], bits [15:11]); addr_valid_o is high for counter values in [0, bits [5:4]); as_o stays 0.
- R8: Handshaking mode: ack_i is sampled at the edge where the counter equals bits [3:2] + bits [1:0]; if low the counter holds and the enable stays high; the counter advances on the edge where ack_i is seen high. ack_i has no effect at any other counter value.
- R9: Handshaking mode: a request is refused when bits [1:0] are 0, bits [3:2] are 0, bits [10:6] are less than bits [15:11], bits [15:11] are not greater than bits [3:2] + bits [1:0], or ratio_i is not 2'b10 (4:1).
- R10: A refused request (including ratio_i = 2'b11 in either mode) gives busy_o, done_o and cfg_err_o high for exactly the one cycle after the accepting edge, with every strobe 0, then returns to idle. ratio_i codes: 00 = 1:1, 01 = 2:1, 10 = 4:1, 11 reserved.
- R11: While an access runs, bus16_o and mclk_sync_o equal word bits [4] and [2] in fixed mode and are both 1 in handshaking mode; they are 0 otherwise.
- R12: The word, hs_mode_i, ratio_i and write_i are captured at acceptance; changing them during an access has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Access request, taken when idle |
| write_i | input | 1 | 1 = write access, 0 = read access |
| hs_mode_i | input | 1 | 1 = handshaking mode, 0 = fixed-wait mode |
| ratio_i | input | 2 | Memory-clock to system-clock ratio code |
| cfg_word_i | input | 16 | Timing configuration word |
| ack_i | input | 1 | External acknowledge (handshaking mode) |
| busy_o | output | 1 | Access or refusal in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| cfg_err_o | output | 1 | Request refused for illegal configuration |
| as_o | output | 1 | Address strobe |
| re_o | output | 1 | Read enable |
| we_o | output | 1 | Write enable |
| addr_valid_o | output | 1 | Address output window |
| bus16_o | output | 1 | 16-bit bus width selected |
| mclk_sync_o | output | 1 | Bus timed to the memory clock |

## Verification
Every output is decoded from the registered counter and state, so the value for counter c is visible in the cycle that follows the edge that produced c: the first cycle after the accepting edge shows c = 0, and a refusal shows its done and error flags in that same first cycle and clears them one cycle later. The bench keeps its own count of c, drives inputs and samples outputs on the falling edge, advances its count only when the rising edge should advance the design, and holds it on edges where it drives acknowledge low at the sample point. After the done cycle it samples once more to see busy low; during the access it scrambles the configuration inputs and toggles acknowledge away from the sample point to show those changes have no effect.

// File: rtl/stb_timer_pkg.sv
// Shared types for the external bus strobe sequencer.
// Assumes offsets never exceed 31 memory-clock cycles (5-bit fields).
package stb_timer_pkg;

    localparam int OFS_W = 5;
    localparam int CFG_W = 16;

    typedef logic [OFS_W-1:0] ofs_t;

    // memory-clock / system-clock ratio codes
    typedef enum logic [1:0] {
        RATIO_1   = 2'b00,
        RATIO_2   = 2'b01,
        RATIO_4   = 2'b10,
        RATIO_RSV = 2'b11
    } ratio_e;

    // decoded timing of one access
    typedef struct packed {
        logic hs;
        ofs_t as_on;
        ofs_t as_off;
        ofs_t en_on;
        ofs_t en_off;
        ofs_t adr_off;
        ofs_t cyc_end;
        ofs_t chk_at;
        logic bus16;
        logic mclk_sync;
    } tcfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_FAIL = 2'd2
    } seq_e;

endpackage

// File: rtl/stb_cfg_decode.sv
// Decodes the configuration word into per-edge offsets for either timing
// mode and judges whether the request is legal.
// Assumes: purely combinational, evaluated on live inputs at acceptance.
module stb_cfg_decode
    import stb_timer_pkg::*;
#(
    parameter int EN_ON_FIXED = 1
) (
    input  logic [CFG_W-1:0] word,
    input  logic             hs_mode,
    input  logic [1:0]       ratio,
    output tcfg_t            cfg,
    output logic             legal
);

    localparam ofs_t EN_ON_F = ofs_t'(EN_ON_FIXED);
    localparam ofs_t WEN_MIN = ofs_t'(3);

    ofs_t f_asa, f_asn, f_wen;
    ofs_t f_dw, f_ea, f_ae, f_bce, f_ren, f_chk;
    logic ok_fixed, ok_hs;

    // split the word into both views
    always_comb begin
        f_asa = ofs_t'(word[7:6]);
        f_asn = ofs_t'(word[10:8]);
        f_wen = ofs_t'(word[15:11]);
        f_dw  = ofs_t'(word[1:0]);
        f_ea  = ofs_t'(word[3:2]);
        f_ae  = ofs_t'(word[5:4]);
        f_bce = ofs_t'(word[10:6]);
        f_ren = ofs_t'(word[15:11]);
        f_chk = f_ea + f_dw;
    end

    // legality rules per mode
    always_comb begin
        ok_fixed = (f_asn != '0) && (f_asn >= f_asa) &&
                   (f_wen >= WEN_MIN) && (f_wen >= EN_ON_F) &&
                   (ratio != RATIO_RSV);
        ok_hs    = (f_dw != '0) && (f_ea != '0) && (f_bce >= f_ren) &&
                   (f_ren > f_chk) && (ratio == RATIO_4);
        legal    = hs_mode ? ok_hs : ok_fixed;
    end

    // assemble the offsets of the selected mode
    always_comb begin
        cfg.hs = hs_mode;
        if (hs_mode) begin
            cfg.as_on     = '0;
            cfg.as_off    = '0;
            cfg.en_on     = f_ea;
            cfg.en_off    = f_ren;
            cfg.adr_off   = f_ae;
            cfg.cyc_end   = f_bce;
            cfg.chk_at    = f_chk;
            cfg.bus16     = 1'b1;
            cfg.mclk_sync = 1'b1;
        end else begin
            cfg.as_on     = f_asa;
            cfg.as_off    = f_asn;
            cfg.en_on     = EN_ON_F;
            cfg.en_off    = f_wen;
            cfg.adr_off   = f_asn;
            cfg.cyc_end   = f_wen;
            cfg.chk_at    = '0;
            cfg.bus16     = word[4];
            cfg.mclk_sync = word[2];
        end
    end

endmodule

// File: rtl/stb_window.sv
// One strobe window: high while enabled and on <= cnt < off.
// Assumes the counter only moves forward within an access.
module stb_window
    import stb_timer_pkg::*;
(
    input  logic en,
    input  ofs_t cnt,
    input  ofs_t on_at,
    input  ofs_t off_at,
    output logic active
);

    // compare the counter against both edges
    always_comb begin
        active = en && (cnt >= on_at) && (cnt < off_at);
    end

endmodule

// File: rtl/stb_sequencer.sv
// Access state machine and cycle counter. Accepts a start while idle,
// counts to the bus-cycle end, stalls at the acknowledge sample point in
// handshaking mode, and spends one cycle in a refusal state for an
// illegal request. Assumes chk_at < cyc_end for any legal access.
module stb_sequencer
    import stb_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal_now,
    input  logic hs,
    input  ofs_t chk_at,
    input  ofs_t cyc_end,
    input  logic ack,
    output ofs_t cnt,
    output logic run,
    output logic fail,
    output logic done,
    output logic accept
);

    seq_e st;
    logic stall;

    // decode state into handshake signals
    always_comb begin
        run    = (st == SEQ_RUN);
        fail   = (st == SEQ_FAIL);
        accept = (st == SEQ_IDLE) && start;
        stall  = hs && (cnt == chk_at) && !ack;
        done   = (run && (cnt == cyc_end)) || fail;
    end

    // advance state and counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        cnt <= '0;
                        st  <= legal_now ? SEQ_RUN : SEQ_FAIL;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == cyc_end) begin
                        st <= SEQ_IDLE;
                    end else if (!stall) begin
                        cnt <= cnt + ofs_t'(1);
                    end
                end
                SEQ_FAIL: st <= SEQ_IDLE;
                default:  st <= SEQ_IDLE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= cyc_end)); // R3
    AST_BUSY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && start && (cnt != cyc_end)) |=> run); // R2
    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hs && (cnt == chk_at) && !ack) |=> (run && $stable(cnt))); // R8
    AST_FAIL_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!fail && !run)); // R10

endmodule

// File: rtl/ext_strobe_timer.sv
// Top of the external bus strobe sequencer. Decodes the configuration,
// captures it at acceptance, runs the cycle counter and derives the
// address strobe, enables and address window from per-edge offsets.
// Assumes clk is the memory clock and inputs are synchronous to it.
module ext_strobe_timer
    import stb_timer_pkg::*;
#(
    parameter int EN_ON_FIXED = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             write_i,
    input  logic             hs_mode_i,
    input  logic [1:0]       ratio_i,
    input  logic [CFG_W-1:0] cfg_word_i,
    input  logic             ack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             cfg_err_o,
    output logic             as_o,
    output logic             re_o,
    output logic             we_o,
    output logic             addr_valid_o,
    output logic             bus16_o,
    output logic             mclk_sync_o
);

    localparam int N_WIN = 3;
    localparam int W_AS  = 0;
    localparam int W_EN  = 1;
    localparam int W_ADR = 2;

    tcfg_t cfg_now, cfg_q;
    logic  legal_now;
    logic  wr_q;
    ofs_t  cnt;
    logic  run, fail, done, accept;
    ofs_t  win_on  [N_WIN];
    ofs_t  win_off [N_WIN];
    logic  win_act [N_WIN];

    stb_cfg_decode #(.EN_ON_FIXED(EN_ON_FIXED)) dec_i (
        .word    (cfg_word_i),
        .hs_mode (hs_mode_i),
        .ratio   (ratio_i),
        .cfg     (cfg_now),
        .legal   (legal_now)
    );

    // capture the access setup on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            wr_q  <= 1'b0;
        end else if (accept) begin
            cfg_q <= cfg_now;
            wr_q  <= write_i;
        end
    end

    stb_sequencer seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .legal_now (legal_now),
        .hs        (cfg_q.hs),
        .chk_at    (cfg_q.chk_at),
        .cyc_end   (cfg_q.cyc_end),
        .ack       (ack_i),
        .cnt       (cnt),
        .run       (run),
        .fail      (fail),
        .done      (done),
        .accept    (accept)
    );

    // edge offsets of each strobe window
    always_comb begin
        win_on[W_AS]   = cfg_q.as_on;
        win_off[W_AS]  = cfg_q.as_off;
        win_on[W_EN]   = cfg_q.en_on;
        win_off[W_EN]  = cfg_q.en_off;
        win_on[W_ADR]  = '0;
        win_off[W_ADR] = cfg_q.adr_off;
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        stb_window win_i (
            .en     (run),
            .cnt    (cnt),
            .on_at  (win_on[g]),
            .off_at (win_off[g]),
            .active (win_act[g])
        );
    end

    // drive the pins from the windows and state
    always_comb begin
        as_o         = win_act[W_AS];
        re_o         = win_act[W_EN] && !wr_q;
        we_o         = win_act[W_EN] && wr_q;
        addr_valid_o = win_act[W_ADR];
        busy_o       = run || fail;
        done_o       = done;
        cfg_err_o    = fail;
        bus16_o      = run && cfg_q.bus16;
        mclk_sync_o  = run && cfg_q.mclk_sync;
    end

    AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(re_o && we_o)); // R5
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (!as_o && !re_o && !we_o && !addr_valid_o && done_o)); // R10
    AST_AS_INSIDE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> addr_valid_o); // R4
    AST_HS_NO_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_q.hs) |-> !as_o); // R7

endmodule

// File: tb/ext_strobe_timer_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module ext_strobe_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic        hs_mode_i = 1'b0;
    logic [1:0]  ratio_i = 2'b00;
    logic [15:0] cfg_word_i = 16'h0000;
    logic        ack_i = 1'b1;
    logic busy_o, done_o, cfg_err_o, as_o, re_o, we_o, addr_valid_o;
    logic bus16_o, mclk_sync_o;

    int n_checks = 0;
    int n_err    = 0;
    int cyc      = 0;

    always #2 clk = ~clk;

    ext_strobe_timer dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .write_i(write_i),
        .hs_mode_i(hs_mode_i), .ratio_i(ratio_i), .cfg_word_i(cfg_word_i),
        .ack_i(ack_i), .busy_o(busy_o), .done_o(done_o), .cfg_err_o(cfg_err_o),
        .as_o(as_o), .re_o(re_o), .we_o(we_o), .addr_valid_o(addr_valid_o),
        .bus16_o(bus16_o), .mclk_sync_o(mclk_sync_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    task automatic check_idle(input string req);
        chk(req, "busy", busy_o, 0);
        chk(req, "done", done_o, 0);
        chk(req, "err", cfg_err_o, 0);
        chk(req, "strobes", {as_o, re_o, we_o, addr_valid_o}, 0);
        chk(req, "attr", {bus16_o, mclk_sync_o}, 0);
    endtask

    // legal access: bench model of the counter drives expectations
    task automatic run_access(input logic [15:0] w, input bit hs, input bit wr,
                              input logic [1:0] ratio, input int holds, input bit poke);
        int c = 0;
        int h = holds;
        int asa = w[7:6], asn = w[10:8], wen = w[15:11];
        int dw = w[1:0], ea = w[3:2], ae = w[5:4], bce = w[10:6], ren = w[15:11];
        int fin = hs ? bce : wen;
        int chkp = ea + dw;
        bit e_as, e_adr, e_en;
        @(negedge clk);
        cfg_word_i = w; hs_mode_i = hs; write_i = wr; ratio_i = ratio;
        start_i = 1'b1; ack_i = 1'b1;
        @(posedge clk);
        while (1'b1) begin
            @(negedge clk);
            start_i = poke;              // R2: ignored while busy
            cfg_word_i = ~w;             // R12: scrambled setup
            write_i = ~wr; hs_mode_i = ~hs; ratio_i = ~ratio;
            if (hs) begin
                e_as = 0; e_adr = (c < ae); e_en = (c >= ea) && (c < ren);
                chk("R7", "as", as_o, 0);
                chk("R7", "addr_valid", addr_valid_o, e_adr);
                chk("R7", "enable", wr ? we_o : re_o, e_en);
            end else begin
                e_as = (c >= asa) && (c < asn); e_adr = (c < asn); e_en = (c >= 1) && (c < wen);
                chk("R4", "as", as_o, e_as);
                chk("R4", "addr_valid", addr_valid_o, e_adr);
                chk("R5", "enable", wr ? we_o : re_o, e_en);
            end
            chk("R5", "other enable", wr ? re_o : we_o, 0);
            chk("R2", "busy", busy_o, 1);
            chk("R3", "done", done_o, (c == fin) ? 1 : 0);
            chk("R10", "err", cfg_err_o, 0);
            chk("R11", "bus16", bus16_o, hs ? 1 : w[4]);
            chk("R11", "mclk_sync", mclk_sync_o, hs ? 1 : w[2]);
            if (c == fin) begin
                start_i = 1'b0;
                break;
            end
            if (hs && c == chkp) begin
                if (h > 0) begin
                    ack_i = 1'b0; h--;   // R8: stall here
                end else begin
                    ack_i = 1'b1; c++;
                end
            end else begin
                ack_i = 1'b0;            // R8: ack ignored off the sample point
                c++;
            end
        end
        @(negedge clk);
        ack_i = 1'b1;
        chk("R3", "busy after done", busy_o, 0);
        chk("R3", "done after done", done_o, 0);
    endtask

    // refused access
    task automatic run_reject(input logic [15:0] w, input bit hs,
                              input logic [1:0] ratio, input string req);
        @(negedge clk);
        cfg_word_i = w; hs_mode_i = hs; ratio_i = ratio; write_i = 1'b1; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk(req, "err flag", cfg_err_o, 1);
        chk("R10", "done", done_o, 1);
        chk("R10", "busy", busy_o, 1);
        chk("R10", "strobes", {as_o, re_o, we_o, addr_valid_o}, 0);
        @(negedge clk);
        chk("R10", "err cleared", cfg_err_o, 0);
        chk("R10", "done cleared", done_o, 0);
        chk("R10", "busy cleared", busy_o, 0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle("R1");
        start_i = 1'b1;               // start during reset must not be taken
        @(negedge clk);
        check_idle("R1");
        start_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");
    endtask

    initial begin
        test_reset();
        run_access(16'hEB50, 1'b0, 1'b0, 2'b00, 0, 1'b0);   // reset word, read
        run_access(16'h2C84, 1'b0, 1'b1, 2'b01, 0, 1'b1);   // write, start held
        run_access(16'h1BD0, 1'b0, 1'b0, 2'b10, 0, 1'b0);   // empty AS, min WEN
        run_access(16'h4326, 1'b1, 1'b0, 2'b10, 0, 1'b0);   // handshake read
        run_access(16'h4326, 1'b1, 1'b1, 2'b10, 3, 1'b1);   // handshake write, stalls
        run_access(16'h39CF, 1'b1, 1'b0, 2'b10, 1, 1'b0);   // end equals release
        run_reject(16'hE850, 1'b0, 2'b00, "R6");            // ASN zero
        run_reject(16'hEAD0, 1'b0, 2'b00, "R6");            // ASN below ASA
        run_reject(16'h1350, 1'b0, 2'b00, "R6");            // WEN too small
        run_reject(16'h4324, 1'b1, 2'b10, "R9");            // DW zero
        run_reject(16'h4322, 1'b1, 2'b10, "R9");            // EA zero
        run_reject(16'h41E6, 1'b1, 2'b10, "R9");            // end before release
        run_reject(16'h1B26, 1'b1, 2'b10, "R9");            // release before sample
        run_reject(16'h4326, 1'b1, 2'b01, "R9");            // wrong ratio
        run_reject(16'hEB50, 1'b0, 2'b11, "R10");           // reserved ratio
        run_access(16'hEB50, 1'b0, 1'b1, 2'b00, 0, 1'b0);   // recovery
        @(negedge clk);
        check_idle("R2");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule